// File: doc/BRIEF.md
# Pattern-Plane Instruction Sequencer

This block is the controller that sits beside a cellular logic array for binary images. It owns three pattern registers, each holding one bit per array cell: the input plane, the output plane and a spare store. It executes a short stored program of 12-bit words. A LOAD word moves whole planes between the registers in one clock. It can also take a fresh scanned frame into the input plane and raise display strobes. A PROCESS word presents a cell function code and per-instruction options to the array and starts it. It then waits for the array's completion signal and captures the array result into the output plane.

Software-style control is reduced to a few pins. A write port fills the 32-entry program store. A single-step pulse runs the one word at a given address. A run pulse executes the whole store from address 0. A repeat level makes the sequence wrap forever. A stop level ends the run at the next instruction boundary. Options carried by a PROCESS word apply only while that word executes, and every array control returns to its default afterwards.

Top module: `plane_sequencer`

## Requirements
- R1: After reset the block is idle (`busy` low), all three planes and all program words are zero, and the array controls sit at their defaults: function 0, border 0, label all-zero, pixel feed equal to the input plane.
- R2: A write with `progWe` high stores `progData` at `progAddr` in the 32-word program store, and later execution follows the stored words.
- R3: A word with bit 11 = 0 is a LOAD that completes in one clock. Bit 0 loads the input plane from `scanData` and pulses `showIn`. Bit 1 pulses `showOut`. Bit 2 sets the input plane to the bitwise complement of the output plane, and it overrides bit 0 for the input plane. Bit 3 copies the output plane into the spare store. Any combination of these acts together.
- R4: A word with bit 11 = 1 is a PROCESS. Its bits 7:0 appear on `arrFunc` from the clock after the word is reached until the array reports done, and `arrStart` is high for exactly the first of those cycles.
- R5: PROCESS bit 8 (swap) feeds the array pixel input from the spare store and takes the label source from the input plane. With bit 8 clear, the pixel input is the input plane and the label source is the spare store.
- R6: PROCESS bit 9 (label gate) drives the label source onto `arrLabel`. With bit 9 clear, `arrLabel` is all zero.
- R7: PROCESS bit 10 (border) drives `arrBorder` high while that word executes.
- R8: Outside a PROCESS wait, every option reverts: `arrFunc` is 0, `arrBorder` is 0, `arrLabel` is zero, and `arrPix` equals the input plane.
- R9: While a PROCESS waits, a cycle with `arrDone` high loads `arrResult` into the output plane, and the next word is reached at that same clock.
- R10: A LOAD word with bits 3:0 all zero is an unused entry. It is passed over in one clock and changes no plane and no strobe.
- R11: A `runOne` pulse executes only the word at `progAddr` and then returns to idle.
- R12: A `runAll` pulse executes words 0 to 31 in order and returns to idle after word 31. With `repeatMode` high, execution continues from word 0 after word 31.
- R13: `busy` is high from the clock after a run pulse until the run ends. A high `stopReq` ends the run at the next instruction boundary and never cuts short a PROCESS wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| progWe | input | 1 | Program store write enable |
| progAddr | input | 5 | Write address, also the single-step address |
| progData | input | 12 | Instruction word to store |
| runOne | input | 1 | Pulse: execute one word |
| runAll | input | 1 | Pulse: execute the whole store |
| repeatMode | input | 1 | Wrap from word 31 to word 0 |
| stopReq | input | 1 | End the run at the next boundary |
| scanData | input | 192 | Scanned frame for the input plane |
| arrDone | input | 1 | Array result valid |
| arrResult | input | 192 | Array output pattern |
| arrFunc | output | 8 | Cell function code |
| arrBorder | output | 1 | Margin interconnection level |
| arrStart | output | 1 | One-cycle array start |
| arrPix | output | 192 | Pixel pattern to the array |
| arrLabel | output | 192 | Label pattern to the array gates |
| planeIn | output | 192 | Input plane contents |
| planeOut | output | 192 | Output plane contents |
| planeSpare | output | 192 | Spare store contents |
| showIn | output | 1 | Input plane display strobe |
| showOut | output | 1 | Output plane display strobe |
| busy | output | 1 | A run is in progress |

## Verification
A run pulse is seen at one rising edge, and its first word is reached at the next. A LOAD shows its plane changes and display strobes one clock after it is reached. A PROCESS raises `arrStart` and its options one clock after it is reached. Its captured result appears in `planeOut` one clock after the edge that samples `arrDone`. The bench keeps a behavioural model that advances at every rising edge using the same sampled inputs. It compares every output at the following falling edge, so each result is checked in the exact cycle it is due. The emulated array in the bench answers after a latency that varies from one to four cycles, so done arriving in the start cycle and done arriving later are both covered.

// File: rtl/cla_seq_pkg.sv
package cla_seq_pkg;
  localparam int unsigned INSTR_W    = 12;
  localparam int unsigned FUNC_W     = 8;
  localparam int unsigned KIND_BIT   = 11;
  localparam int unsigned BORDER_BIT = 10;
  localparam int unsigned GATE_BIT   = 9;
  localparam int unsigned SWAP_BIT   = 8;
  localparam int unsigned OP_SCAN    = 0;
  localparam int unsigned OP_SHOW    = 1;
  localparam int unsigned OP_COMP    = 2;
  localparam int unsigned OP_SPARE   = 3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic scanIn;
    logic compIn;
    logic copySpare;
    logic capOut;
  } planeStrobes_t;

  // options held while a PROCESS word waits on the array
  typedef struct packed {
    logic [FUNC_W-1:0] func;
    logic              swap;
    logic              gate;
    logic              border;
    logic              active;
  } arrayCtl_t;
endpackage

// File: rtl/plane_dp.sv
module plane_dp
  import cla_seq_pkg::*;
#(
  parameter int unsigned CELLS = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  planeStrobes_t    strb,
  input  arrayCtl_t        ctl,
  input  logic [CELLS-1:0] scanData,
  input  logic [CELLS-1:0] arrResult,
  output logic [CELLS-1:0] planeIn,
  output logic [CELLS-1:0] planeOut,
  output logic [CELLS-1:0] planeSpare,
  output logic [CELLS-1:0] arrPix,
  output logic [CELLS-1:0] arrLabel
);
  logic [CELLS-1:0] labelSrc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      planeIn    <= '0;
      planeOut   <= '0;
      planeSpare <= '0;
    end else begin
      if (strb.compIn)         planeIn <= ~planeOut;
      else if (strb.scanIn)    planeIn <= scanData;
      if (strb.copySpare)      planeSpare <= planeOut;
      if (strb.capOut)         planeOut <= arrResult;
    end
  end

  always_comb begin
    arrPix   = (ctl.active && ctl.swap) ? planeSpare : planeIn;
    labelSrc = ctl.swap ? planeIn : planeSpare;
    arrLabel = (ctl.active && ctl.gate) ? labelSrc : '0;
  end

  assert_comp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.compIn |=> planeIn == ~$past(planeOut));
  assert_spare_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.copySpare |=> planeSpare == $past(planeOut));
  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capOut |=> planeOut == $past(arrResult));
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capOut |=> $stable(planeOut));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import cla_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               progWe,
  input  logic [AW-1:0]      progAddr,
  input  logic [INSTR_W-1:0] progData,
  input  logic               runOne,
  input  logic               runAll,
  input  logic               repeatMode,
  input  logic               stopReq,
  input  logic               arrDone,
  output planeStrobes_t      strb,
  output arrayCtl_t          ctl,
  output logic               arrStart,
  output logic               showIn,
  output logic               showOut,
  output logic               busy
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [INSTR_W-1:0] store [DEPTH];
  seqState_t          state;
  logic [AW-1:0]      pc;
  logic               single;
  logic [INSTR_W-1:0] word;
  logic               isProc, loadGo, endRun;
  logic [AW-1:0]      pcNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (progWe) begin
      store[progAddr] <= progData;
    end
  end

  always_comb begin
    word    = store[pc];
    isProc  = word[KIND_BIT];
    loadGo  = (state == S_RUN) && !isProc;
    endRun  = single || stopReq || ((pc == LAST) && !repeatMode);
    pcNext  = (pc == LAST) ? '0 : pc + 1'b1;
    strb.scanIn    = loadGo && word[OP_SCAN];
    strb.compIn    = loadGo && word[OP_COMP];
    strb.copySpare = loadGo && word[OP_SPARE];
    strb.capOut    = (state == S_WAIT) && arrDone;
    busy           = (state != S_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pc       <= '0;
      single   <= 1'b0;
      ctl      <= '0;
      arrStart <= 1'b0;
      showIn   <= 1'b0;
      showOut  <= 1'b0;
    end else begin
      arrStart <= 1'b0;
      showIn   <= loadGo && word[OP_SCAN];
      showOut  <= loadGo && word[OP_SHOW];
      unique case (state)
        S_IDLE: begin
          if (runOne) begin
            pc     <= progAddr;
            single <= 1'b1;
            state  <= S_RUN;
          end else if (runAll) begin
            pc     <= '0;
            single <= 1'b0;
            state  <= S_RUN;
          end
        end
        S_RUN: begin
          if (isProc) begin
            ctl.func   <= word[FUNC_W-1:0];
            ctl.swap   <= word[SWAP_BIT];
            ctl.gate   <= word[GATE_BIT];
            ctl.border <= word[BORDER_BIT];
            ctl.active <= 1'b1;
            arrStart   <= 1'b1;
            state      <= S_WAIT;
          end else if (endRun) begin
            state <= S_IDLE;
          end else begin
            pc <= pcNext;
          end
        end
        S_WAIT: begin
          if (arrDone) begin
            ctl <= '0;
            if (endRun) state <= S_IDLE;
            else begin
              pc    <= pcNext;
              state <= S_RUN;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arrStart |=> !arrStart);
  assert_func_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.active && !arrDone) |=> (ctl.active && $stable(ctl.func)));
  assert_revert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.active |-> (ctl.func == '0 && !ctl.border && !ctl.gate && !ctl.swap));
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!arrStart && !ctl.active && strb == '0));
  assert_one_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (single && loadGo) |=> !busy);
  assert_wait_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !arrDone) |=> busy);
endmodule

// File: rtl/plane_sequencer.sv
module plane_sequencer
  import cla_seq_pkg::*;
#(
  parameter int unsigned CELLS = 192,
  parameter int unsigned DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       progWe,
  input  logic [$clog2(DEPTH)-1:0]   progAddr,
  input  logic [INSTR_W-1:0]         progData,
  input  logic                       runOne,
  input  logic                       runAll,
  input  logic                       repeatMode,
  input  logic                       stopReq,
  input  logic [CELLS-1:0]           scanData,
  input  logic                       arrDone,
  input  logic [CELLS-1:0]           arrResult,
  output logic [FUNC_W-1:0]          arrFunc,
  output logic                       arrBorder,
  output logic                       arrStart,
  output logic [CELLS-1:0]           arrPix,
  output logic [CELLS-1:0]           arrLabel,
  output logic [CELLS-1:0]           planeIn,
  output logic [CELLS-1:0]           planeOut,
  output logic [CELLS-1:0]           planeSpare,
  output logic                       showIn,
  output logic                       showOut,
  output logic                       busy
);
  localparam int unsigned AW = $clog2(DEPTH);

  planeStrobes_t strb;
  arrayCtl_t     ctl;

  seq_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .progWe(progWe), .progAddr(progAddr),
    .progData(progData), .runOne(runOne), .runAll(runAll),
    .repeatMode(repeatMode), .stopReq(stopReq), .arrDone(arrDone),
    .strb(strb), .ctl(ctl), .arrStart(arrStart), .showIn(showIn),
    .showOut(showOut), .busy(busy)
  );

  plane_dp #(.CELLS(CELLS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .ctl(ctl),
    .scanData(scanData), .arrResult(arrResult), .planeIn(planeIn),
    .planeOut(planeOut), .planeSpare(planeSpare), .arrPix(arrPix),
    .arrLabel(arrLabel)
  );

  assign arrFunc   = ctl.func;
  assign arrBorder = ctl.border;
endmodule

// File: tb/plane_sequencer_tb.sv
module plane_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic progWe = 1'b0;
  logic [4:0] progAddr = '0;
  logic [11:0] progData = '0;
  logic runOne = 1'b0, runAll = 1'b0, repeatMode = 1'b0, stopReq = 1'b0;
  logic [N-1:0] scanData = '0;
  logic arrDone = 1'b0;
  logic [N-1:0] arrResult = '0;
  logic [7:0] arrFunc;
  logic arrBorder, arrStart, showIn, showOut, busy;
  logic [N-1:0] arrPix, arrLabel, planeIn, planeOut, planeSpare;

  always #(CLK_PERIOD/2) clk = ~clk;

  plane_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .progWe(progWe), .progAddr(progAddr),
    .progData(progData), .runOne(runOne), .runAll(runAll),
    .repeatMode(repeatMode), .stopReq(stopReq), .scanData(scanData),
    .arrDone(arrDone), .arrResult(arrResult), .arrFunc(arrFunc),
    .arrBorder(arrBorder), .arrStart(arrStart), .arrPix(arrPix),
    .arrLabel(arrLabel), .planeIn(planeIn), .planeOut(planeOut),
    .planeSpare(planeSpare), .showIn(showIn), .showOut(showOut), .busy(busy)
  );

  int nChecks = 0, nFail = 0, cyc = 0, starts = 0, latSeed = 0, doneCnt = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  // behavioural reference model
  logic [11:0] mMem [32];
  int mState = 0, mPc = 0;
  bit mSingle = 0, mStart = 0, mShowIn = 0, mShowOut = 0;
  logic [7:0] mFunc = '0;
  bit mSw = 0, mGt = 0, mBd = 0;
  logic [N-1:0] mIn = '0, mOut = '0, mSpare = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mMem[i]) mMem[i] = '0;
      mState = 0; mPc = 0; mSingle = 0; mStart = 0; mShowIn = 0; mShowOut = 0;
      mFunc = '0; mSw = 0; mGt = 0; mBd = 0; mIn = '0; mOut = '0; mSpare = '0;
    end else begin
      logic [11:0] w;
      bit adv;
      w = mMem[mPc];
      adv = 0;
      mShowIn = 0; mShowOut = 0; mStart = 0;
      if (mState == 0) begin
        if (runOne) begin mPc = progAddr; mSingle = 1; mState = 1; end
        else if (runAll) begin mPc = 0; mSingle = 0; mState = 1; end
      end else if (mState == 1) begin
        if (w[11]) begin
          mState = 2; mFunc = w[7:0]; mSw = w[8]; mGt = w[9]; mBd = w[10]; mStart = 1;
        end else begin
          mShowIn = w[0]; mShowOut = w[1];
          if (w[3]) mSpare = mOut;
          if (w[2]) mIn = ~mOut; else if (w[0]) mIn = scanData;
          adv = 1;
        end
      end else begin
        if (arrDone) begin
          mOut = arrResult; mFunc = '0; mSw = 0; mGt = 0; mBd = 0; adv = 1;
          mState = 1;
        end
      end
      if (adv) begin
        if (mSingle || stopReq || (mPc == 31 && !repeatMode)) mState = 0;
        else mPc = (mPc + 1) % 32;
      end
      if (progWe) mMem[progAddr] = progData;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit act;
      logic [N-1:0] ePix, eLab;
      act = (mState == 2);
      ePix = (act && mSw) ? mSpare : mIn;
      eLab = (act && mGt) ? (mSw ? mIn : mSpare) : '0;
      chk("R13 busy", N'(busy), N'(mState != 0));
      chk("R4 arrStart", N'(arrStart), N'(mStart));
      chk("R4 arrFunc", N'(arrFunc), N'(act ? mFunc : 8'h00));
      chk("R7 arrBorder", N'(arrBorder), N'(act && mBd));
      chk("R5 arrPix", arrPix, ePix);
      chk("R6 arrLabel", arrLabel, eLab);
      chk("R3 planeIn", planeIn, mIn);
      chk("R9 planeOut", planeOut, mOut);
      chk("R3 planeSpare", planeSpare, mSpare);
      chk("R3 showIn", N'(showIn), N'(mShowIn));
      chk("R3 showOut", N'(showOut), N'(mShowOut));
    end
  end

  // emulated array: answers after 1..4 cycles
  always @(negedge clk) begin
    if (arrStart) begin
      starts++;
      latSeed++;
      doneCnt = 1 + (latSeed % 4);
    end else if (doneCnt > 0) begin
      doneCnt--;
    end
    arrDone = (doneCnt == 1);
    arrResult = arrPix ^ {arrLabel[0], arrLabel[N-1:1]} ^ {24{arrFunc}} ^ {N{arrBorder}};
    scanData = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      nFail++;
      $display("FAIL R13 watchdog actual=hung expected=idle");
      finish_run();
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic put(input int a, input logic [11:0] d);
    progWe = 1; progAddr = 5'(a); progData = d; tick(); progWe = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 5000 && busy; i++) tick();
  endtask

  initial begin
    logic [N-1:0] sIn, sOut, sSpare;
    int s0;
    tick(); tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 busy", N'(busy), '0);
    chk("R1 planes", planeIn | planeOut | planeSpare, '0);
    chk("R1 arrFunc", N'(arrFunc), '0);
    chk("R1 arrPix", arrPix, planeIn);

    // R2 program: scan, process gated, copy+show, process swap/gate/border, comp, scan+comp
    put(0, 12'h001);
    put(1, 12'hA3C);
    put(2, 12'h00A);
    put(3, 12'hFA5);
    put(4, 12'h004);
    put(5, 12'h005);
    put(6, 12'h80F);
    put(7, 12'h000);
    put(8, 12'h001);
    s0 = starts;
    runAll = 1; tick(); runAll = 0;
    waitIdle();
    tick();
    chk("R2 R12 run ends idle", N'(busy), '0);
    chk("R2 process count", N'(starts - s0), N'(3));
    // R8 defaults restored
    chk("R8 arrFunc", N'(arrFunc), '0);
    chk("R8 arrBorder", N'(arrBorder), '0);
    chk("R8 arrLabel", arrLabel, '0);
    chk("R8 arrPix", arrPix, planeIn);

    // R11 single step of word 3 only
    sIn = planeIn;
    s0 = starts;
    progAddr = 5'd3; runOne = 1; tick(); runOne = 0;
    waitIdle();
    tick();
    chk("R11 single process", N'(starts - s0), N'(1));
    chk("R11 next word not run", planeIn, sIn);

    // R10 unused entry: no effect
    sIn = planeIn; sOut = planeOut; sSpare = planeSpare;
    progAddr = 5'd7; runOne = 1; tick(); runOne = 0;
    chk("R10 busy during skip", N'(busy), N'(1));
    tick();
    chk("R10 skip done", N'(busy), '0);
    chk("R10 planes unchanged", {planeIn ^ sIn} | {planeOut ^ sOut} | {planeSpare ^ sSpare}, '0);
    chk("R10 no strobe", N'(showIn | showOut), '0);

    // R12 repeat wraps; R13 stop at boundary
    s0 = starts;
    repeatMode = 1;
    runAll = 1; tick(); runAll = 0;
    for (int i = 0; i < 120; i++) tick();
    chk("R12 wrap ran several passes", N'((starts - s0) >= 5), N'(1));
    stopReq = 1;
    waitIdle();
    tick();
    chk("R13 stop ends run", N'(busy), '0);
    stopReq = 0; repeatMode = 0;
    tick(); tick();
    finish_run();
  end
endmodule